// File: doc/BRIEF.md
# Output Fault High-Impedance Controller

This block decides when timer output pins must stop driving and go to high impedance. It watches several independent fault sources: two software force bits, an oscillator-stop indication gated by an enable, two external event pulses, four active-low input-level detectors and a comparator that looks for both outputs of any complementary pair being active at once. Each source latches its fault and has its own rule for release. Some flag-clear writes are refused while the condition behind the flag has not yet gone away.

The pins form two groups: the complementary PWM group (three pairs, six pins) and a single-channel timer group (four pins). A mask register for each group selects the pins that a fault affects. The block produces one registered high-Z enable per pin. Software reaches it through a small register port with a synchronous write and a combinational read.

Register map (3-bit address, 8-bit data):
- 0: control. Bit 0 is the PWM force, bit 1 is the single-channel force, bit 2 is the oscillator-stop enable.
- 1: PWM group mask.
- 2: single-channel group mask.
- 3: detector modes. Input i uses bits 2i+1:2i.
- 4: flags. Bits 3:0 are the input flags, bit 4 is the comparator flag, bit 5 is the oscillator-stop flag.

Top module: `fhz_ctrl`

## Requirements
- R1: Writing control bit 0 (or bit 1) high forces every mask-selected pin of the PWM group (or of the single-channel group) to high impedance. Writing the bit low releases those pins.
- R2: An oscillator-stop pulse sets the oscillator flag (flags bit 5) only while the enable (control bit 2) is 1. While both the flag and the enable are 1, the mask-selected pins of both groups are high impedance. Clearing either one releases them.
- R3: A one-cycle pulse on `evt_pwm_i` or `evt_sc_i` sets the force bit of that group. The visible effect is the same as a software write of 1 to that bit.
- R4: Any set input flag puts the mask-selected pins of both groups in high impedance. The pins are released only once all four input flags are clear.
- R5: Mode 00 sets an input flag on a falling edge of its pin. Modes 01, 10 and 11 set the flag after 16 consecutive low samples, taken at one cycle in 8, 16 or 128 of a free-running prescaler. A high sample restarts the count.
- R6: In modes 01, 10 and 11, a write of 0 to a set input flag is refused until the pin has been sampled high since the flag was set.
- R7: The comparator flag (flags bit 4) is set when both pins of any pair in `pwm_lvl_i` (bits 2p and 2p+1) are high in the same cycle. This flag affects only the PWM group. A write of 0 to it is refused while any bit of `pwm_lvl_i` is high.
- R8: Each high-Z output equals its mask bit ANDed with the OR of the active faults for its group. The output is registered, so it follows the source state one clock edge later.
- R9: After reset, all flags, force bits, enables, masks and modes are 0, and every high-Z output is 0.
- R10: In the flags register, writing 1 to a bit leaves it unchanged and writing 0 requests a clear. A set request takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| evt_pwm_i | input | 1 | Event pulse for the PWM group force bit |
| evt_sc_i | input | 1 | Event pulse for the single-channel force bit |
| osc_stop_i | input | 1 | Oscillator-stop indication |
| in_pin_i | input | 4 | Active-low fault input pins |
| pwm_lvl_i | input | 6 | Present complementary output levels, high is active |
| hz_pwm_o | output | 6 | High-Z enables for the PWM group |
| hz_sc_o | output | 4 | High-Z enables for the single-channel group |

## Verification
The hardest case to reach is the refused clear in a sampling mode. A pin has to stay low for more than sixteen prescaler samples to set its flag. A clear is then attempted while the pin is still low, which must fail. The pin is then raised long enough for a high sample to land, and the same clear must now succeed. The stimulus holds the pin low for a computed number of cycles and mixes in a second flag set by a falling edge, which shows that one clear write removes only the flags it is allowed to remove. The comparator refusal is reached in the same way: one pin is left active after the overlap.

// File: rtl/fhz_pkg.sv
package fhz_pkg;
  typedef enum logic [1:0] {
    DET_EDGE   = 2'b00,
    DET_DIV8   = 2'b01,
    DET_DIV16  = 2'b10,
    DET_DIV128 = 2'b11
  } det_mode_e;

  localparam int unsigned AW      = 3;
  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_MPWM  = 3'd1;
  localparam logic [AW-1:0] A_MSC   = 3'd2;
  localparam logic [AW-1:0] A_MODE  = 3'd3;
  localparam logic [AW-1:0] A_FLAGS = 3'd4;

  localparam int unsigned RUN_LEN = 16;
  localparam int unsigned RUN_W   = $clog2(RUN_LEN) + 1;
endpackage

// File: rtl/fhz_prescale.sv
module fhz_prescale #(
  parameter int unsigned CW = 7
) (
  input  logic       clk_i,
  input  logic       rst_n,
  output logic [2:0] tick_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o[0] = &cnt_q[2:0];
  assign tick_o[1] = &cnt_q[3:0];
  assign tick_o[2] = &cnt_q;
endmodule

// File: rtl/fhz_in_det.sv
module fhz_in_det
  import fhz_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n,
  input  logic      pin_i,
  input  det_mode_e mode_i,
  input  logic [2:0] tick_i,
  input  logic      clr_i,
  output logic      flag_o
);
  logic             pin_q;
  logic             flag_q, flag_d;
  logic             seen_q, seen_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             tick_sel, set_c, clr_ok;

  always_comb begin
    case (mode_i)
      DET_DIV8:   tick_sel = tick_i[0];
      DET_DIV16:  tick_sel = tick_i[1];
      DET_DIV128: tick_sel = tick_i[2];
      default:    tick_sel = 1'b0;
    endcase
  end

  always_comb begin
    run_d  = run_q;
    seen_d = seen_q;
    flag_d = flag_q;
    set_c  = 1'b0;
    if (mode_i == DET_EDGE) begin
      set_c = pin_q & ~pin_i;
      run_d = '0;
    end else if (tick_sel) begin
      if (!pin_i) begin
        run_d = (run_q == RUN_W'(RUN_LEN)) ? run_q : run_q + 1'b1;
        set_c = (run_d == RUN_W'(RUN_LEN));
      end else begin
        run_d  = '0;
        seen_d = seen_q | flag_q;
      end
    end
    clr_ok = (mode_i == DET_EDGE) || seen_q;
    if (set_c) begin
      flag_d = 1'b1;
      seen_d = 1'b0;
    end else if (clr_i && clr_ok) begin
      flag_d = 1'b0;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      pin_q  <= pin_i;
      flag_q <= flag_d;
      seen_q <= seen_d;
      run_q  <= run_d;
    end
  end

  assign flag_o = flag_q;

  AST_LOW_CLR_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag_q && mode_i != DET_EDGE && !seen_q) |=> flag_o); // R6
  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_i == DET_EDGE && pin_q && !pin_i) |=> flag_o); // R5
endmodule

// File: rtl/fhz_out_cmp.sv
module fhz_out_cmp #(
  parameter int unsigned NPAIR = 3
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic [2*NPAIR-1:0] lvl_i,
  input  logic               clr_i,
  output logic               flag_o
);
  logic [NPAIR-1:0] both;
  logic             flag_q, flag_d;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign both[p] = lvl_i[2*p] & lvl_i[2*p+1];
  end

  always_comb begin
    flag_d = flag_q;
    if (|both)                     flag_d = 1'b1;
    else if (clr_i && !(|lvl_i))   flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_CMP_CLR_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag_q && |lvl_i) |=> flag_o); // R7
  AST_CMP_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|both) |=> flag_o); // R7
endmodule

// File: rtl/fhz_ctrl.sv
module fhz_ctrl
  import fhz_pkg::*;
#(
  parameter int unsigned NPAIR = 3,
  parameter int unsigned NSC   = 4,
  parameter int unsigned NIN   = 4,
  parameter int unsigned DW    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 evt_pwm_i,
  input  logic                 evt_sc_i,
  input  logic                 osc_stop_i,
  input  logic [NIN-1:0]       in_pin_i,
  input  logic [2*NPAIR-1:0]   pwm_lvl_i,
  output logic [2*NPAIR-1:0]   hz_pwm_o,
  output logic [NSC-1:0]       hz_sc_o
);
  localparam int unsigned NPWM   = 2 * NPAIR;
  localparam int unsigned B_CMP  = NIN;
  localparam int unsigned B_OSC  = NIN + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              force_pwm_q, force_pwm_d;
  logic              force_sc_q, force_sc_d;
  logic              osc_en_q, osc_en_d;
  logic              osc_flag_q, osc_flag_d;
  logic [NPWM-1:0]   mask_pwm_q, mask_pwm_d;
  logic [NSC-1:0]    mask_sc_q, mask_sc_d;
  logic [2*NIN-1:0]  mode_q, mode_d;
  logic [NPWM-1:0]   hz_pwm_d;
  logic [NSC-1:0]    hz_sc_d;
  logic [NIN-1:0]    in_flag;
  logic [2:0]        ticks;
  logic              cmp_flag;
  logic              wr_ctrl, wr_mpwm, wr_msc, wr_mode, wr_flags;
  logic              osc_hz, in_hz, fault_pwm, fault_sc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_mpwm  = wr_en_i && (addr_i == A_MPWM);
  assign wr_msc   = wr_en_i && (addr_i == A_MSC);
  assign wr_mode  = wr_en_i && (addr_i == A_MODE);
  assign wr_flags = wr_en_i && (addr_i == A_FLAGS);

  fhz_prescale #(.CW(7)) u_pre (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .tick_o(ticks)
  );

  for (genvar i = 0; i < NIN; i++) begin : g_det
    fhz_in_det u_det (
      .clk_i (clk_i),
      .rst_n (rst_n),
      .pin_i (in_pin_i[i]),
      .mode_i(det_mode_e'(mode_q[2*i +: 2])),
      .tick_i(ticks),
      .clr_i (wr_flags && !wdata_i[i]),
      .flag_o(in_flag[i])
    );
  end

  fhz_out_cmp #(.NPAIR(NPAIR)) u_cmp (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .lvl_i (pwm_lvl_i),
    .clr_i (wr_flags && !wdata_i[B_CMP]),
    .flag_o(cmp_flag)
  );

  always_comb begin
    force_pwm_d = wr_ctrl ? wdata_i[0] : force_pwm_q;
    force_sc_d  = wr_ctrl ? wdata_i[1] : force_sc_q;
    osc_en_d    = wr_ctrl ? wdata_i[2] : osc_en_q;
    if (evt_pwm_i) force_pwm_d = 1'b1;
    if (evt_sc_i)  force_sc_d  = 1'b1;
    mask_pwm_d  = wr_mpwm ? wdata_i[NPWM-1:0] : mask_pwm_q;
    mask_sc_d   = wr_msc  ? wdata_i[NSC-1:0]  : mask_sc_q;
    mode_d      = wr_mode ? wdata_i[2*NIN-1:0] : mode_q;
    osc_flag_d  = osc_flag_q;
    if (osc_stop_i && osc_en_q)           osc_flag_d = 1'b1;
    else if (wr_flags && !wdata_i[B_OSC]) osc_flag_d = 1'b0;
  end

  always_comb begin
    osc_hz    = osc_flag_q & osc_en_q;
    in_hz     = |in_flag;
    fault_sc  = force_sc_q | osc_hz | in_hz;
    fault_pwm = force_pwm_q | osc_hz | in_hz | cmp_flag;
    hz_pwm_d  = mask_pwm_q & {NPWM{fault_pwm}};
    hz_sc_d   = mask_sc_q & {NSC{fault_sc}};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      force_pwm_q <= 1'b0;
      force_sc_q  <= 1'b0;
      osc_en_q    <= 1'b0;
      osc_flag_q  <= 1'b0;
      mask_pwm_q  <= '0;
      mask_sc_q   <= '0;
      mode_q      <= '0;
      hz_pwm_o    <= '0;
      hz_sc_o     <= '0;
    end else begin
      force_pwm_q <= force_pwm_d;
      force_sc_q  <= force_sc_d;
      osc_en_q    <= osc_en_d;
      osc_flag_q  <= osc_flag_d;
      mask_pwm_q  <= mask_pwm_d;
      mask_sc_q   <= mask_sc_d;
      mode_q      <= mode_d;
      hz_pwm_o    <= hz_pwm_d;
      hz_sc_o     <= hz_sc_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[2:0]      = {osc_en_q, force_sc_q, force_pwm_q};
      A_MPWM:  rdata_o[NPWM-1:0] = mask_pwm_q;
      A_MSC:   rdata_o[NSC-1:0]  = mask_sc_q;
      A_MODE:  rdata_o[2*NIN-1:0] = mode_q;
      A_FLAGS: rdata_o[NIN+1:0]  = {osc_flag_q, cmp_flag, in_flag};
      default: rdata_o = '0;
    endcase
  end

  AST_HZ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hz_pwm_o & ~$past(mask_pwm_q)) == '0); // R8
  AST_FORCE_SC: assert property (@(posedge clk_i) disable iff (!rst_n)
    force_sc_q |=> (hz_sc_o == $past(mask_sc_q))); // R1
  AST_OSC_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!osc_en_q && !osc_flag_q) |=> !osc_flag_q); // R2
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_pwm_i |=> force_pwm_q); // R3
endmodule

// File: tb/fhz_ctrl_tb.sv
module fhz_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       evt_pwm, evt_sc, osc_stop;
  logic [3:0] in_pin;
  logic [5:0] pwm_lvl;
  logic [5:0] hz_pwm;
  logic [3:0] hz_sc;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  fhz_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_pwm_i(evt_pwm),
    .evt_sc_i(evt_sc), .osc_stop_i(osc_stop), .in_pin_i(in_pin),
    .pwm_lvl_i(pwm_lvl), .hz_pwm_o(hz_pwm), .hz_sc_o(hz_sc)
  );

  function automatic logic [5:0] exp_pwm(logic [5:0] m, logic f);
    return f ? m : 6'h00;
  endfunction
  function automatic logic [3:0] exp_sc(logic [3:0] m, logic f);
    return f ? m : 4'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_hz(string req, logic [5:0] ep, logic [3:0] es);
    chk(req, {26'd0, hz_pwm}, {26'd0, ep});
    chk(req, {28'd0, hz_sc}, {28'd0, es});
  endtask

  initial begin
    int unsigned cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cnt);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    logic [5:0] mp;
    logic [3:0] ms;
    logic [1:0] fc;
    void'($urandom(32'd17));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    evt_pwm = 0; evt_sc = 0; osc_stop = 0; in_pin = 4'hF; pwm_lvl = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R9 reset state
    chk_hz("R9", 6'h00, 4'h0);
    rd(3'd0, r); chk("R9 ctrl", {24'd0, r}, 32'd0);
    rd(3'd4, r); chk("R9 flags", {24'd0, r}, 32'd0);

    // R1 / R8 random masks and force bits
    for (int k = 0; k < 40; k++) begin
      mp = 6'($urandom); ms = 4'($urandom); fc = 2'($urandom);
      wr(3'd1, {2'b00, mp});
      wr(3'd2, {4'h0, ms});
      wr(3'd0, {6'd0, fc});
      cyc(1);
      chk_hz("R1 R8 force/mask", exp_pwm(mp, fc[0]), exp_sc(ms, fc[1]));
    end
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h3F);
    wr(3'd2, 8'h0F);
    cyc(1);
    chk_hz("R1 release", 6'h00, 4'h0);

    // R3 event pulse on single-channel group
    @(negedge clk); evt_sc = 1'b1;
    @(negedge clk); evt_sc = 1'b0;
    cyc(1);
    chk_hz("R3 evt sc", 6'h00, 4'hF);
    rd(3'd0, r); chk("R3 ctrl bit", {24'd0, r}, 32'h02);
    @(negedge clk); evt_pwm = 1'b1;
    @(negedge clk); evt_pwm = 1'b0;
    cyc(1);
    chk_hz("R3 evt pwm", 6'h3F, 4'hF);
    wr(3'd0, 8'h00);
    cyc(1);
    chk_hz("R3 R1 cleared", 6'h00, 4'h0);

    // R2 oscillator stop
    @(negedge clk); osc_stop = 1'b1;
    @(negedge clk); osc_stop = 1'b0;
    cyc(1);
    rd(3'd4, r); chk("R2 gated flag", {24'd0, r}, 32'd0);
    chk_hz("R2 gated", 6'h00, 4'h0);
    wr(3'd0, 8'h04);
    @(negedge clk); osc_stop = 1'b1;
    @(negedge clk); osc_stop = 1'b0;
    cyc(1);
    chk_hz("R2 osc hz", 6'h3F, 4'hF);
    wr(3'd0, 8'h00);
    cyc(1);
    chk_hz("R2 release by enable", 6'h00, 4'h0);
    rd(3'd4, r); chk("R2 flag kept", {24'd0, r}, 32'h20);
    wr(3'd0, 8'h04);
    cyc(1);
    chk_hz("R2 re-enable", 6'h3F, 4'hF);
    wr(3'd4, 8'h1F);
    cyc(1);
    chk_hz("R2 R10 release by flag", 6'h00, 4'h0);
    wr(3'd0, 8'h00);

    // R5 edge mode on input 0
    @(negedge clk); in_pin[0] = 1'b0;
    cyc(2);
    chk_hz("R5 R4 edge", 6'h3F, 4'hF);
    rd(3'd4, r); chk("R5 flag0", {24'd0, r}, 32'h01);
    wr(3'd4, 8'h3E);
    cyc(1);
    rd(3'd4, r); chk("R10 edge clear", {24'd0, r}, 32'h00);
    chk_hz("R4 release", 6'h00, 4'h0);
    in_pin[0] = 1'b1;

    // R5 sampling mode div8 on input 1: too short, then long enough
    wr(3'd3, 8'h04);
    in_pin[1] = 1'b0; cyc(8 * 14);
    in_pin[1] = 1'b1; cyc(20);
    rd(3'd4, r); chk("R5 short low", {24'd0, r}, 32'h00);
    in_pin[1] = 1'b0; cyc(8 * 18);
    rd(3'd4, r); chk("R5 div8 flag", {24'd0, r}, 32'h02);
    in_pin[2] = 1'b0; cyc(2);
    rd(3'd4, r); chk("R5 flag2 edge", {24'd0, r}, 32'h06);
    wr(3'd4, 8'h39);
    cyc(1);
    rd(3'd4, r); chk("R6 R10 partial clear", {24'd0, r}, 32'h02);
    chk_hz("R4 one flag holds", 6'h3F, 4'hF);
    in_pin[1] = 1'b1; in_pin[2] = 1'b1; cyc(20);
    wr(3'd4, 8'h3D);
    cyc(1);
    rd(3'd4, r); chk("R6 clear after high", {24'd0, r}, 32'h00);
    chk_hz("R4 all clear", 6'h00, 4'h0);

    // R5 div128 on input 3
    wr(3'd3, 8'hC0);
    in_pin[3] = 1'b0; cyc(128 * 18);
    rd(3'd4, r); chk("R5 div128 flag", {24'd0, r}, 32'h08);
    wr(3'd4, 8'h37);
    cyc(1);
    rd(3'd4, r); chk("R6 refused div128", {24'd0, r}, 32'h08);
    in_pin[3] = 1'b1; cyc(140);
    wr(3'd4, 8'h37);
    cyc(1);
    rd(3'd4, r); chk("R6 div128 clear", {24'd0, r}, 32'h00);
    wr(3'd3, 8'h00);

    // R7 comparator
    @(negedge clk); pwm_lvl = 6'b001001;
    cyc(2);
    rd(3'd4, r); chk("R7 no pair overlap", {24'd0, r}, 32'h00);
    pwm_lvl = 6'b001100;
    @(negedge clk); pwm_lvl = 6'b000100;
    cyc(1);
    chk_hz("R7 pwm only", 6'h3F, 4'h0);
    rd(3'd4, r); chk("R7 flag", {24'd0, r}, 32'h10);
    wr(3'd4, 8'h2F);
    cyc(1);
    rd(3'd4, r); chk("R7 clear refused", {24'd0, r}, 32'h10);
    pwm_lvl = 6'b000000;
    wr(3'd4, 8'h2F);
    cyc(1);
    rd(3'd4, r); chk("R7 clear ok", {24'd0, r}, 32'h00);
    chk_hz("R7 release", 6'h00, 4'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule